// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block runs whole operations against an 8-bit large-page NAND device. A page holds 2048 main bytes and 64 spare bytes, and a block holds 64 pages. The requester gives a start pulse, an operation code and a byte address. The block then lowers chip enable and issues the command, address and read cycles in the right order. It waits where the device goes busy, and it streams any bytes it reads out through a valid/ready port. When the operation ends it releases chip enable and pulses done.

Pin-level timing is not handled here. Each command, address or read cycle is handed to a simple cycle layer as a request that stays stable until that layer acknowledges it. The device's ready/busy level is watched through a flag that is set on its rising edge. The sequencer clears this flag while it sends the command that makes the device busy, and it then waits for the flag rather than for the live level. A programmable cycle limit bounds the wait. If no ready edge arrives within the limit, the operation is aborted with an error.

The address is split into two column bytes and three row bytes. The column is bits 11:0 and the row is bits 28:12. Unused upper bits of the second and fifth cycles are driven low.

Top module: `nand_op_seq`

## Requirements
- R1: Operation code 0 (reset) lowers chip enable and issues one command cycle of data 0xFF. It then waits for the ready flag and ends with a done pulse. It produces no error and no output bytes.
- R2: Operation code 1 (identify) issues command 0x90, then one address cycle of 0x00, then exactly four read cycles with no ready wait. The four bytes are delivered in the order read, and the last marker is set on the fourth.
- R3: Operation code 2 (page read) issues command 0x00, five address cycles and command 0x30, then waits for the ready flag, then issues read cycles. Cycle kind is encoded 0 = command, 1 = address, 2 = read. Kind and data of a requested cycle stay stable until it is acknowledged.
- R4: The five page-read address bytes are, in order: A[7:0]; {0000, A[11:8]}; A[19:12]; A[27:20]; {0000000, A[28]}.
- R5: A page read streams 2112 minus the column (A[11:0]) bytes, with the last marker on the final byte. A column of 2112 or more is rejected: error and done are raised, and no bus cycle is issued.
- R6: The ready flag is cleared while the busy-making command (0xFF or 0x30) is outstanding. A ready rising edge seen before that command does not end the following wait.
- R7: If no ready rising edge arrives within tmo_limit cycles of waiting, error and done are raised. No read cycle follows.
- R8: A presented output byte and its last marker stay stable until accepted. No read cycle is requested while a byte is waiting.
- R9: Chip enable (active low) is high after reset and while idle. It goes low when an operation is accepted, stays low through its last bus cycle, and is high in the done cycle.
- R10: Operation code 3 is rejected: error and done are raised, chip enable stays high, and no bus cycle is issued.
- R11: Start pulses while busy is high are ignored.
- R12: Done lasts one cycle. Error holds until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start an operation (taken when idle) |
| op | input | 2 | 0 reset, 1 identify, 2 page read, 3 invalid |
| addr | input | 29 | Byte address: column in 11:0, row in 28:12 |
| tmo_limit | input | 16 | Maximum wait cycles for the ready edge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Timeout or rejected request; held until next accepted start |
| ce_n | output | 1 | Device chip enable, active low |
| bus_req | output | 1 | Cycle request to the pin layer |
| bus_kind | output | 2 | 0 command, 1 address, 2 read |
| bus_wdata | output | 8 | Command or address byte |
| bus_ack | input | 1 | Pin layer finished the requested cycle |
| bus_rdata | input | 8 | Byte read, valid with bus_ack on a read |
| rb | input | 1 | Device ready (high) / busy (low), synchronous |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the operation |
| out_ready | input | 1 | Consumer accepts the output byte |

## Verification
The hardest case to reach is a stale ready edge. The device must show a rising ready edge while the block is idle and then never go busy after the command that follows. Only then does the flag-clearing rule decide between a clean finish and a timeout. The bench's device model has a switch that withholds the busy period and a request that pulses ready low and back high while idle. Both are used together before a reset operation, and the bench expects an error. Timeouts, rejected columns and stray starts during a page read are brought about the same way, while the consumer's ready is throttled to hold bytes on the output.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [1:0] {
        OP_RESET  = 2'd0,
        OP_READID = 2'd1,
        OP_PAGE   = 2'd2,
        OP_BAD    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        BK_CMD  = 2'd0,
        BK_ADDR = 2'd1,
        BK_READ = 2'd2
    } bkind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_ADDR, S_CONF, S_WAIT, S_READ, S_OUT, S_FIN
    } st_e;

    localparam logic [7:0] NC_RESET   = 8'hFF;
    localparam logic [7:0] NC_IDENT   = 8'h90;
    localparam logic [7:0] NC_PGREAD  = 8'h00;
    localparam logic [7:0] NC_CONFIRM = 8'h30;
    localparam logic [7:0] NC_ID_ADR  = 8'h00;

endpackage

// File: rtl/nand_addr_split.sv
module nand_addr_split #(
    parameter int COL_BITS = 12,
    parameter int ROW_BITS = 17,
    parameter int COL_CYC  = 2,
    parameter int ROW_CYC  = 3
) (
    input  logic [COL_BITS+ROW_BITS-1:0]      addr,
    output logic [COL_CYC+ROW_CYC-1:0][7:0]   cyc_bytes
);
    logic [8*COL_CYC-1:0] col_ext;
    logic [8*ROW_CYC-1:0] row_ext;

    // zero-extend so that bits above the field go out low
    always_comb begin
        col_ext = '0;
        row_ext = '0;
        col_ext[COL_BITS-1:0] = addr[COL_BITS-1:0];
        row_ext[ROW_BITS-1:0] = addr[COL_BITS+ROW_BITS-1:COL_BITS];
    end

    for (genvar i = 0; i < COL_CYC + ROW_CYC; i++) begin : g_cyc
        if (i < COL_CYC) begin : g_col
            assign cyc_bytes[i] = col_ext[8*i +: 8];
        end else begin : g_row
            assign cyc_bytes[i] = row_ext[8*(i-COL_CYC) +: 8];
        end
    end
endmodule

// File: rtl/nand_rdy_wait.sv
module nand_rdy_wait #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rb,
    input  logic             clr,
    input  logic             arm,
    input  logic [TMO_W-1:0] limit,
    output logic             flag,
    output logic             expired
);
    typedef struct packed {
        logic             rb;
        logic             flag;
        logic [TMO_W-1:0] cnt;
    } wregs_t;

    wregs_t q, d;

    always_comb begin
        d    = q;
        d.rb = rb;
        if (clr)
            d.flag = 1'b0;
        else if (rb && !q.rb)
            d.flag = 1'b1;
        if (!arm)
            d.cnt = '0;
        else if (q.cnt != limit)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.rb   <= 1'b1;
            q.flag <= 1'b0;
            q.cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    assign flag    = q.flag;
    assign expired = arm && (q.cnt == limit);

    p_rise_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && $rose(rb)) |=> flag);
    p_clear_drops_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_BITS   = 12,
    parameter int ROW_BITS   = 17,
    parameter int PAGE_MAIN  = 2048,
    parameter int PAGE_SPARE = 64,
    parameter int ID_BYTES   = 4,
    parameter int TMO_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [1:0]                   op,
    input  logic [COL_BITS+ROW_BITS-1:0] addr,
    input  logic [TMO_W-1:0]             tmo_limit,
    output logic                         busy,
    output logic                         done,
    output logic                         error,
    output logic                         ce_n,
    output logic                         bus_req,
    output logic [1:0]                   bus_kind,
    output logic [7:0]                   bus_wdata,
    input  logic                         bus_ack,
    input  logic [7:0]                   bus_rdata,
    input  logic                         rb,
    output logic                         out_valid,
    output logic [7:0]                   out_data,
    output logic                         out_last,
    input  logic                         out_ready
);
    localparam int ADDR_W     = COL_BITS + ROW_BITS;
    localparam int PAGE_TOTAL = PAGE_MAIN + PAGE_SPARE;
    localparam int CNT_W      = $clog2(PAGE_TOTAL + 1);
    localparam int COL_CYC    = (COL_BITS + 7) / 8;
    localparam int ROW_CYC    = (ROW_BITS + 7) / 8;
    localparam int ADDR_CYC   = COL_CYC + ROW_CYC;
    localparam int STEP_W     = $clog2(ADDR_CYC);

    typedef struct packed {
        st_e               st;
        op_e               op;
        logic [ADDR_W-1:0] adr;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  rem;
        logic [7:0]        hold;
        logic              err;
    } regs_t;

    regs_t q, d;

    logic [ADDR_CYC-1:0][7:0] abytes;
    logic                     rdy_clr;
    logic                     rdy_flag;
    logic                     tmo_hit;
    logic                     wait_arm;
    logic                     col_oob;
    logic [CNT_W-1:0]         page_len;
    op_e                      op_in;

    nand_addr_split #(
        .COL_BITS(COL_BITS),
        .ROW_BITS(ROW_BITS),
        .COL_CYC (COL_CYC),
        .ROW_CYC (ROW_CYC)
    ) u_split (
        .addr     (q.adr),
        .cyc_bytes(abytes)
    );

    assign wait_arm = (q.st == S_WAIT);

    nand_rdy_wait #(.TMO_W(TMO_W)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .rb     (rb),
        .clr    (rdy_clr),
        .arm    (wait_arm),
        .limit  (tmo_limit),
        .flag   (rdy_flag),
        .expired(tmo_hit)
    );

    assign op_in    = op_e'(op);
    assign col_oob  = int'(addr[COL_BITS-1:0]) >= PAGE_TOTAL;
    assign page_len = CNT_W'(PAGE_TOTAL - int'(q.adr[COL_BITS-1:0]));

    always_comb begin
        d       = q;
        rdy_clr = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.err  = 1'b0;
                    d.op   = op_in;
                    d.adr  = addr;
                    d.step = '0;
                    if (op_in == OP_BAD || (op_in == OP_PAGE && col_oob)) begin
                        d.err = 1'b1;
                        d.st  = S_FIN;
                    end else begin
                        d.st = S_CMD;
                    end
                end
            end
            S_CMD: begin
                rdy_clr = (q.op == OP_RESET);
                if (bus_ack)
                    d.st = (q.op == OP_RESET) ? S_WAIT : S_ADDR;
            end
            S_ADDR: begin
                if (bus_ack) begin
                    if (q.op == OP_READID) begin
                        d.st  = S_READ;
                        d.rem = CNT_W'(ID_BYTES);
                    end else if (q.step == STEP_W'(ADDR_CYC - 1)) begin
                        d.st = S_CONF;
                    end else begin
                        d.step = q.step + 1'b1;
                    end
                end
            end
            S_CONF: begin
                rdy_clr = 1'b1;
                if (bus_ack)
                    d.st = S_WAIT;
            end
            S_WAIT: begin
                if (rdy_flag) begin
                    if (q.op == OP_PAGE) begin
                        d.st  = S_READ;
                        d.rem = page_len;
                    end else begin
                        d.st = S_FIN;
                    end
                end else if (tmo_hit) begin
                    d.err = 1'b1;
                    d.st  = S_FIN;
                end
            end
            S_READ: begin
                if (bus_ack) begin
                    d.hold = bus_rdata;
                    d.st   = S_OUT;
                end
            end
            S_OUT: begin
                if (out_ready) begin
                    if (q.rem == CNT_W'(1)) begin
                        d.st = S_FIN;
                    end else begin
                        d.rem = q.rem - 1'b1;
                        d.st  = S_READ;
                    end
                end
            end
            S_FIN:   d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= S_IDLE;
            q.op   <= OP_RESET;
            q.adr  <= '0;
            q.step <= '0;
            q.rem  <= '0;
            q.hold <= '0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_wdata = 8'h00;
        bus_kind  = BK_CMD;
        unique case (q.st)
            S_CMD: begin
                if (q.op == OP_RESET)
                    bus_wdata = NC_RESET;
                else if (q.op == OP_READID)
                    bus_wdata = NC_IDENT;
                else
                    bus_wdata = NC_PGREAD;
            end
            S_ADDR: begin
                bus_kind  = BK_ADDR;
                bus_wdata = (q.op == OP_READID) ? NC_ID_ADR : abytes[q.step];
            end
            S_CONF:  bus_wdata = NC_CONFIRM;
            S_READ:  bus_kind  = BK_READ;
            default: bus_wdata = 8'h00;
        endcase
    end

    assign bus_req   = (q.st == S_CMD) || (q.st == S_ADDR) ||
                       (q.st == S_CONF) || (q.st == S_READ);
    assign ce_n      = (q.st == S_IDLE) || (q.st == S_FIN);
    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_FIN);
    assign error     = q.err;
    assign out_valid = (q.st == S_OUT);
    assign out_data  = q.hold;
    assign out_last  = (q.st == S_OUT) && (q.rem == CNT_W'(1));

    p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wdata) && $stable(bus_kind)));
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    p_timeout_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_arm && tmo_hit && !rdy_flag) |=> (done && error && !bus_req));
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 2'd3) |=> (done && error && ce_n));
    p_ce_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op != 2'd3 && !col_oob) |=> (!ce_n && bus_req));
    p_id_no_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_ADDR && bus_ack && q.op == OP_READID) |=> (bus_req && bus_kind == BK_READ));
endmodule

// File: tb/sim_nand_op_seq.sv
module sim_nand_op_seq;
    localparam int PAGE_TOTAL = 2112;
    localparam int BUSY_LEN   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [28:0] addr = '0;
    logic [15:0] tmo_limit = 16'd100;
    logic        busy, done, error, ce_n, bus_req;
    logic [1:0]  bus_kind;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = 8'h00;
    logic        rb = 1'b1;
    logic        out_valid, out_last;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;

    always #10 clk = ~clk;

    nand_op_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
        .tmo_limit(tmo_limit), .busy(busy), .done(done), .error(error),
        .ce_n(ce_n), .bus_req(bus_req), .bus_kind(bus_kind), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .rb(rb),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready)
    );

    int    checks = 0;
    int    errors = 0;
    int    q_kind[$];
    int    q_data[$];
    int    out_q[$];
    int    n_out = 0;
    int    exp_len = 0;
    string tag = "R9";
    bit    dev_busy_en = 1'b1;
    bit    throttle = 1'b0;
    bit    glitch = 1'b0;
    int    busy_cnt = 0;
    int    dev_mode = 0;
    int    dev_idx = 0;
    int    dev_col = 0;
    int    dev_row8 = 0;
    bit    hold_pend = 1'b0;
    int    hold_val = 0;
    int    cyc = 0;

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
        end
    endtask

    function automatic int id_byte(input int i);
        case (i)
            0: return 8'hEC;
            1: return 8'hDA;
            2: return 8'h10;
            default: return 8'h95;
        endcase
    endfunction

    // device, pin layer and consumer model, acting away from the active edge
    always @(negedge clk) begin
        int ek;
        int ed;
        int rd;
        cyc++;
        if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) rb = 1'b1;
        end
        if (glitch) begin
            glitch = 1'b0;
            rb = 1'b0;
            busy_cnt = 1;
        end
        if (hold_pend) begin
            chk({tag, " R8 byte still offered"}, int'(out_valid), 1);
            chk({tag, " R8 byte unchanged"}, int'(out_data), hold_val);
            hold_pend = 1'b0;
        end
        out_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
        if (out_valid) begin
            chk({tag, " R8 no read while byte waits"}, int'(bus_req), 0);
            if (out_ready) begin
                if (out_q.size() == 0) chk({tag, " unexpected output byte"}, 1, 0);
                else chk({tag, " output byte"}, int'(out_data), out_q.pop_front());
                chk({tag, " R5 last marker"}, int'(out_last), int'(n_out + 1 == exp_len));
                n_out++;
            end else begin
                hold_pend = 1'b1;
                hold_val  = int'(out_data);
            end
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            chk({tag, " R9 chip enable low during bus cycle"}, int'(ce_n), 0);
            if (q_kind.size() == 0) begin
                chk({tag, " R3 unexpected bus cycle"}, 1, 0);
            end else begin
                ek = q_kind.pop_front();
                ed = q_data.pop_front();
                chk({tag, " R3 cycle kind"}, int'(bus_kind), ek);
                if (ek != 2) chk({tag, " R4 cycle data"}, int'(bus_wdata), ed);
            end
            if (bus_kind == 2'd2) begin
                rd = (dev_mode == 1) ? id_byte(dev_idx) : (((dev_col + dev_idx) ^ dev_row8) & 255);
                dev_idx++;
                bus_rdata = rd[7:0];
                out_q.push_back(rd);
            end else if (bus_kind == 2'd0) begin
                if (bus_wdata == 8'hFF || bus_wdata == 8'h30) begin
                    if (dev_busy_en) begin
                        rb = 1'b0;
                        busy_cnt = BUSY_LEN;
                    end
                    dev_mode = 2;
                    dev_idx = 0;
                end
                if (bus_wdata == 8'h90) begin
                    dev_mode = 1;
                    dev_idx = 0;
                end
            end
            bus_ack = 1'b1;
        end
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push_bus(input int k, input int v);
        q_kind.push_back(k);
        q_data.push_back(v);
    endtask

    task automatic run_op(input string t, input int o, input int a, input int eerr,
                          input int elen, input bit rej, input bit stray);
        int w;
        tag = t;
        exp_len = elen;
        n_out = 0;
        dev_col = a & 12'hFFF;
        dev_row8 = (a >> 12) & 255;
        if (!rej) begin
            if (o == 0) push_bus(0, 8'hFF);
            if (o == 1) begin
                push_bus(0, 8'h90);
                push_bus(1, 8'h00);
                for (int i = 0; i < 4; i++) push_bus(2, 0);
            end
            if (o == 2) begin
                push_bus(0, 8'h00);
                push_bus(1, a & 255);
                push_bus(1, (a >> 8) & 15);
                push_bus(1, (a >> 12) & 255);
                push_bus(1, (a >> 20) & 255);
                push_bus(1, (a >> 28) & 1);
                push_bus(0, 8'h30);
                for (int i = 0; i < elen; i++) push_bus(2, 0);
            end
        end
        @(negedge clk);
        start = 1'b1;
        op = o[1:0];
        addr = a[28:0];
        @(negedge clk);
        start = 1'b0;
        if (stray) begin
            repeat (4) @(negedge clk);
            chk({t, " R11 busy during operation"}, int'(busy), 1);
            start = 1'b1;
            op = 2'd0;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 40000) begin
            @(negedge clk);
            w++;
        end
        chk({t, " done seen"}, int'(w < 40000), 1);
        chk({t, " error at done"}, int'(error), eerr);
        chk({t, " R9 chip enable high at done"}, int'(ce_n), 1);
        @(negedge clk);
        chk({t, " R12 done single cycle"}, int'(done), 0);
        chk({t, " R12 error held after done"}, int'(error), eerr);
        chk({t, " R5 output byte count"}, n_out, elen);
        chk({t, " R3 all expected cycles issued"}, q_kind.size(), 0);
        q_kind.delete();
        q_data.delete();
        out_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset chip enable high", int'(ce_n), 1);
        chk("R9 reset no bus request", int'(bus_req), 0);
        chk("R12 reset done low", int'(done), 0);
        chk("R12 reset error low", int'(error), 0);
        chk("R8 reset no output", int'(out_valid), 0);
        chk("R11 reset not busy", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op("R1 reset op", 0, 0, 0, 0, 1'b0, 1'b0);
        run_op("R2 identify", 1, 0, 0, 4, 1'b0, 1'b0);
        throttle = 1'b1;
        run_op("R2 identify throttled", 1, 0, 0, 4, 1'b0, 1'b0);
        run_op("R4 page read mid column", 2, (17'h1ABCD << 12) | 2100, 0, PAGE_TOTAL - 2100, 1'b0, 1'b0);
        throttle = 1'b0;
        run_op("R5 page read last column", 2, (17'h00321 << 12) | 2111, 0, 1, 1'b0, 1'b0);
        run_op("R5 page read full page", 2, (17'h0F0F0 << 12), 0, PAGE_TOTAL, 1'b0, 1'b0);
        run_op("R5 column out of page", 2, (17'h00001 << 12) | 2112, 1, 0, 1'b1, 1'b0);
        run_op("R12 error cleared by start", 0, 0, 0, 0, 1'b0, 1'b0);
        run_op("R10 invalid op", 3, 0, 1, 0, 1'b1, 1'b0);
        chk("R10 chip enable stayed high", int'(ce_n), 1);

        dev_busy_en = 1'b0;
        tmo_limit = 16'd20;
        run_op("R7 timeout without busy", 0, 0, 1, 0, 1'b0, 1'b0);
        dev_busy_en = 1'b1;
        tmo_limit = 16'd100;
        run_op("R12 recover after timeout", 0, 0, 0, 0, 1'b0, 1'b0);

        glitch = 1'b1;
        repeat (4) @(negedge clk);
        dev_busy_en = 1'b0;
        tmo_limit = 16'd20;
        run_op("R6 stale ready edge ignored", 0, 0, 1, 0, 1'b0, 1'b0);
        dev_busy_en = 1'b1;
        tmo_limit = 16'd100;

        throttle = 1'b1;
        run_op("R11 stray start ignored", 2, (17'h10055 << 12) | 2090, 0, PAGE_TOTAL - 2090, 1'b0, 1'b1);
        throttle = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule